// File: doc/BRIEF.md
# Multi-Cycle 8-bit Stack Processor Core

This block is a small processor core with a byte-wide datapath. It has eight 8-bit general registers, a 256-byte memory that holds both code and data, a 3-bit comparison flag register, and a descending stack whose pointer is general register 7. Each instruction is a one-byte opcode followed by zero, one or two operand bytes. The core reads these bytes one per clock and then executes the instruction in a single cycle. It supports load-immediate, print, add, multiply, compare, push, pop, call, return, an unconditional jump, two conditional jumps and halt.

The host fills memory through a byte-wide load port while reset is held high, then releases reset. The core starts at address 0. Every executed print instruction produces a one-clock strobe with a data byte. When the core halts, it holds that state until the next reset. An opcode the core does not recognise also halts it, and additionally raises a fault flag.

The controller is a five-state machine:
- FETCH reads the opcode. It moves to EXEC when the opcode has no operands, and to OPA otherwise.
- OPA reads the first operand. It moves to OPB when two operands are needed, and to EXEC otherwise.
- OPB reads the second operand and always moves to EXEC.
- EXEC performs the instruction. It returns to FETCH, or moves to HALT after a halt or an unknown opcode.
- HALT is absorbing.

Top module: `stack_cpu8`

## Requirements
- R1: While reset is high, every register reads 0 except register 7, which reads 0xF4. The program counter and flags are 0. The outputs print_valid, halted and fault are all 0. These values apply again after every reset, whatever the previous program left behind.
- R2: While rst is high and load_en is high, load_data is written to memory at load_addr on the rising edge. While rst is low, the load port has no effect.
- R3: Opcode bits 7:6 give the number of operand bytes (0, 1 or 2). A register operand names the register given by the low 3 bits of its byte. Any instruction that does not write the PC advances it by 1 plus that count. This includes JEQ and JNE when they are not taken.
- R4: LDI (0x82) writes operand 2 into register operand 1. PRN (0x47) pulses print_valid for exactly one clock, with print_data equal to the named register.
- R5: ADD (0xA0) and MUL (0xA2) write the low 8 bits of the sum or product of both registers into the first register.
- R6: CMP (0xA7) sets the flags to 3'b001 if the registers are equal. It sets 3'b100 if the first is lower and 3'b010 if the first is higher, comparing unsigned.
- R7: JMP (0x54) loads the PC from the named register. JEQ (0x55) does the same only when the flags equal 3'b001. JNE (0x56) does the same only when they do not.
- R8: PUSH (0x45) decrements register 7, then stores the named register at the new address. POP (0x46) loads the named register from the address in register 7, then increments register 7.
- R9: CALL (0x50) pushes the address of the following instruction (PC+2) and jumps to the named register. RET (0x11) pops the PC.
- R10: HLT (0x01) raises halted and keeps it high. Afterwards no further print strobe occurs, and fault stays 0.
- R11: Any other opcode value, such as 0x00 or 0xFF, raises both halted and fault.
- R12: Timing follows the states. An instruction with n operands takes n+2 clocks. After reset is released, a program of LDI, PRN, HLT shows its print strobe on the 7th clock and halted on the 9th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; enables the load port |
| load_en | input | 1 | Memory preload write enable |
| load_addr | input | 8 | Memory preload address |
| load_data | input | 8 | Memory preload byte |
| print_valid | output | 1 | One-clock strobe per executed PRN |
| print_data | output | 8 | Value printed by PRN |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Core stopped on an unknown opcode |

## Verification
Only three things are visible at the ports: the print stream, the halt flag and the fault flag. A wrong register, flag, stack pointer or PC therefore shows up only when a later PRN prints a wrong byte, or when control flow goes astray. Control flow going astray means a skipped or extra print, a loop that never halts, or a spurious fault. These effects usually appear within a few instructions. Each test program therefore prints the state it has just changed. The programs also use taken and untaken jumps, so that a flag error turns into a visible change in the print sequence. Internal checks on the stack pointer, PC step and flag codes report a wrong value one cycle after the EXEC state that produced it.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int DW      = 8;
    localparam int AW      = 8;
    localparam int NREG    = 8;
    localparam int SP_IDX  = 7;
    localparam logic [DW-1:0] SP_INIT = 8'hF4;

    localparam logic [2:0] FLG_EQ = 3'b001;
    localparam logic [2:0] FLG_GT = 3'b010;
    localparam logic [2:0] FLG_LT = 3'b100;

    localparam logic [7:0] OP_HLT  = 8'h01;
    localparam logic [7:0] OP_RET  = 8'h11;
    localparam logic [7:0] OP_PUSH = 8'h45;
    localparam logic [7:0] OP_POP  = 8'h46;
    localparam logic [7:0] OP_PRN  = 8'h47;
    localparam logic [7:0] OP_CALL = 8'h50;
    localparam logic [7:0] OP_JMP  = 8'h54;
    localparam logic [7:0] OP_JEQ  = 8'h55;
    localparam logic [7:0] OP_JNE  = 8'h56;
    localparam logic [7:0] OP_LDI  = 8'h82;
    localparam logic [7:0] OP_ADD  = 8'hA0;
    localparam logic [7:0] OP_MUL  = 8'hA2;
    localparam logic [7:0] OP_CMP  = 8'hA7;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPA,
        ST_OPB,
        ST_EXEC,
        ST_HALT
    } state_e;

endpackage

// File: rtl/cpu8_mem.sv
module cpu8_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
    parameter int              W      = 8,
    parameter int              N      = 8,
    parameter int              SPI    = 7,
    parameter logic [W-1:0]    SP_RST = 8'hF4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [$clog2(N)-1:0] ra_idx,
    input  logic [$clog2(N)-1:0] rb_idx,
    output logic [W-1:0]         ra_data,
    output logic [W-1:0]         rb_data,
    output logic [W-1:0]         sp_data,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [W-1:0]         wr_data,
    input  logic                 sp_we,
    input  logic [W-1:0]         sp_wdata
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic [W-1:0] RST_VAL = (g == SPI) ? SP_RST : '0;
        logic [W-1:0] q;
        if (g == SPI) begin : g_sp
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= RST_VAL;
                end else if (sp_we) begin
                    q <= sp_wdata;
                end else if (wr_en && wr_idx == g[$clog2(N)-1:0]) begin
                    q <= wr_data;
                end
            end
        end else begin : g_gp
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= RST_VAL;
                end else if (wr_en && wr_idx == g[$clog2(N)-1:0]) begin
                    q <= wr_data;
                end
            end
        end
        assign regs[g] = q;
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
    assign sp_data = regs[SPI];

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [W-1:0] prod,
    output logic [2:0]   cmp_code
);
    import cpu8_pkg::*;

    assign sum  = a + b;
    assign prod = a * b;

    always_comb begin
        if (a == b) begin
            cmp_code = FLG_EQ;
        end else if (a < b) begin
            cmp_code = FLG_LT;
        end else begin
            cmp_code = FLG_GT;
        end
    end

endmodule

// File: rtl/stack_cpu8.sv
module stack_cpu8 (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_en,
    input  logic [7:0] load_addr,
    input  logic [7:0] load_data,
    output logic       print_valid,
    output logic [7:0] print_data,
    output logic       halted,
    output logic       fault
);
    import cpu8_pkg::*;

    localparam int IW = $clog2(NREG);

    state_e        state_q, state_d;
    logic [AW-1:0] pc_q, pc_d, pc_seq;
    logic [7:0]    ir_q;
    logic [DW-1:0] opa_q, opb_q;
    logic [2:0]    flags_q, flags_d;
    logic          prn_v_q, fault_q;
    logic [DW-1:0] prn_d_q;
    logic [1:0]    opcnt;

    logic [DW-1:0] rd_a, rd_b, sp_rd;
    logic          rf_we, sp_we;
    logic [IW-1:0] rf_widx;
    logic [DW-1:0] rf_wd, sp_wd;

    logic [DW-1:0] alu_sum, alu_prod;
    logic [2:0]    alu_cmp;

    logic [AW-1:0] mem_raddr, exec_addr, mem_waddr;
    logic [DW-1:0] mem_rdata, mem_wdata, core_wd;
    logic          mem_we, core_we;

    logic do_print, do_halt, do_fault, in_exec;
    logic unused_opnd_hi;

    assign opcnt   = ir_q[7:6];
    assign pc_seq  = pc_q + AW'(opcnt) + AW'(1);
    assign in_exec = (state_q == ST_EXEC);
    assign unused_opnd_hi = ^{opa_q[DW-1:IW], opb_q[DW-1:IW]};

    cpu8_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    cpu8_regfile #(.W(DW), .N(NREG), .SPI(SP_IDX), .SP_RST(SP_INIT)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .ra_idx   (opa_q[IW-1:0]),
        .rb_idx   (opb_q[IW-1:0]),
        .ra_data  (rd_a),
        .rb_data  (rd_b),
        .sp_data  (sp_rd),
        .wr_en    (rf_we & in_exec),
        .wr_idx   (rf_widx),
        .wr_data  (rf_wd),
        .sp_we    (sp_we & in_exec),
        .sp_wdata (sp_wd)
    );

    cpu8_alu #(.W(DW)) u_alu (
        .a        (rd_a),
        .b        (rd_b),
        .sum      (alu_sum),
        .prod     (alu_prod),
        .cmp_code (alu_cmp)
    );

    // Instruction decode for the EXEC state
    always_comb begin
        rf_we     = 1'b0;
        rf_widx   = opa_q[IW-1:0];
        rf_wd     = opb_q;
        sp_we     = 1'b0;
        sp_wd     = sp_rd;
        pc_d      = pc_seq;
        flags_d   = flags_q;
        core_we   = 1'b0;
        core_wd   = rd_a;
        exec_addr = pc_q;
        do_print  = 1'b0;
        do_halt   = 1'b0;
        do_fault  = 1'b0;
        unique case (ir_q)
            OP_LDI: rf_we = 1'b1;
            OP_PRN: do_print = 1'b1;
            OP_ADD: begin
                rf_we = 1'b1;
                rf_wd = alu_sum;
            end
            OP_MUL: begin
                rf_we = 1'b1;
                rf_wd = alu_prod;
            end
            OP_CMP: flags_d = alu_cmp;
            OP_PUSH: begin
                sp_we     = 1'b1;
                sp_wd     = sp_rd - DW'(1);
                exec_addr = sp_rd - DW'(1);
                core_we   = 1'b1;
                core_wd   = rd_a;
            end
            OP_POP: begin
                exec_addr = sp_rd;
                rf_we     = 1'b1;
                rf_wd     = mem_rdata;
                sp_we     = 1'b1;
                sp_wd     = sp_rd + DW'(1);
            end
            OP_CALL: begin
                sp_we     = 1'b1;
                sp_wd     = sp_rd - DW'(1);
                exec_addr = sp_rd - DW'(1);
                core_we   = 1'b1;
                core_wd   = pc_seq;
                pc_d      = rd_a;
            end
            OP_RET: begin
                exec_addr = sp_rd;
                pc_d      = mem_rdata;
                sp_we     = 1'b1;
                sp_wd     = sp_rd + DW'(1);
            end
            OP_JMP: pc_d = rd_a;
            OP_JEQ: if (flags_q == FLG_EQ) pc_d = rd_a;
            OP_JNE: if (flags_q != FLG_EQ) pc_d = rd_a;
            OP_HLT: do_halt = 1'b1;
            default: begin
                do_halt  = 1'b1;
                do_fault = 1'b1;
            end
        endcase
    end

    // Memory address and write-port selection
    always_comb begin
        unique case (state_q)
            ST_FETCH: mem_raddr = pc_q;
            ST_OPA:   mem_raddr = pc_q + AW'(1);
            ST_OPB:   mem_raddr = pc_q + AW'(2);
            ST_EXEC:  mem_raddr = exec_addr;
            default:  mem_raddr = pc_q;
        endcase
        if (rst) begin
            mem_we    = load_en;
            mem_waddr = load_addr;
            mem_wdata = load_data;
        end else begin
            mem_we    = core_we & in_exec;
            mem_waddr = exec_addr;
            mem_wdata = core_wd;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = (mem_rdata[7:6] == 2'd0) ? ST_EXEC : ST_OPA;
            ST_OPA:   state_d = (opcnt >= 2'd2) ? ST_OPB : ST_EXEC;
            ST_OPB:   state_d = ST_EXEC;
            ST_EXEC:  state_d = do_halt ? ST_HALT : ST_FETCH;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            ir_q    <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            flags_q <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH: ir_q  <= mem_rdata;
                ST_OPA:   opa_q <= mem_rdata;
                ST_OPB:   opb_q <= mem_rdata;
                ST_EXEC: begin
                    pc_q    <= pc_d;
                    flags_q <= flags_d;
                end
                default: ;
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            prn_v_q <= 1'b0;
            prn_d_q <= '0;
            fault_q <= 1'b0;
        end else begin
            prn_v_q <= in_exec & do_print;
            if (in_exec & do_print) begin
                prn_d_q <= rd_a;
            end
            if (in_exec & do_fault) begin
                fault_q <= 1'b1;
            end
        end
    end

    assign print_valid = prn_v_q;
    assign print_data  = prn_d_q;
    assign halted      = (state_q == ST_HALT);
    assign fault       = fault_q;

    // Assertions
    assert_ldi_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && ir_q == OP_LDI) |=> (pc_q == $past(pc_q) + AW'(3)));

    assert_print_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        print_valid |=> !print_valid);

    assert_cmp_less_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && ir_q == OP_CMP && rd_a < rd_b) |=> (flags_q == FLG_LT));

    assert_cmp_more_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && ir_q == OP_CMP && rd_a > rd_b) |=> (flags_q == FLG_GT));

    assert_push_sp_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && ir_q == OP_PUSH) |=> (sp_rd == $past(sp_rd) - DW'(1)));

    assert_pop_sp_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && ir_q == OP_POP && opa_q[IW-1:0] != IW'(SP_IDX))
        |=> (sp_rd == $past(sp_rd) + DW'(1)));

    assert_halt_holds_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !print_valid));

    assert_fault_halts_R11: assert property (@(posedge clk) disable iff (rst)
        fault |-> halted);

    assert_no_run_load_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (state_q == ST_EXEC));

endmodule

// File: tb/test_stack_cpu8.sv
module test_stack_cpu8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [7:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic       print_valid;
    logic [7:0] print_data;
    logic       halted;
    logic       fault;

    always #5 clk = ~clk;

    stack_cpu8 i_stack_cpu8 (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .load_addr   (load_addr),
        .load_data   (load_data),
        .print_valid (print_valid),
        .print_data  (print_data),
        .halted      (halted),
        .fault       (fault)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Observation of the print stream, counted in clocks since reset release
    int         cyc;
    int         nprint;
    int         first_prn;
    int         first_halt;
    logic [7:0] cap [8];

    always @(negedge clk) begin
        if (rst) begin
            cyc        = 0;
            nprint     = 0;
            first_prn  = -1;
            first_halt = -1;
        end else begin
            cyc++;
            if (print_valid) begin
                if (nprint < 8) cap[nprint] = print_data;
                if (first_prn < 0) first_prn = cyc;
                nprint++;
            end
            if (halted && first_halt < 0) first_halt = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Programs: bytes right-justified, byte 0 is the leftmost of LEN bytes
    localparam int NPROG = 9;
    localparam logic [255:0] PROG [NPROG] = '{
        // 0: R4 LDI then PRN, R10 HLT
        {8'h82,8'h00,8'h2A, 8'h47,8'h00, 8'h01},
        // 1: R5 ADD wraps 0xC8+0x64, MUL wraps 0x10*0x11
        {8'h82,8'h00,8'hC8, 8'h82,8'h01,8'h64, 8'hA0,8'h00,8'h01, 8'h47,8'h00,
         8'h82,8'h02,8'h10, 8'h82,8'h03,8'h11, 8'hA2,8'h02,8'h03, 8'h47,8'h02, 8'h01},
        // 2: R8 PUSH predecrements, POP restores value and pointer
        {8'h82,8'h00,8'hAA, 8'h45,8'h00, 8'h47,8'h07, 8'h46,8'h01, 8'h47,8'h01,
         8'h47,8'h07, 8'h01},
        // 3: R6 equal compare, R7 JEQ taken, JNE not taken, R3 step
        {8'h82,8'h00,8'h05, 8'h82,8'h01,8'h05, 8'h82,8'h02,8'h10, 8'hA7,8'h00,8'h01,
         8'h55,8'h02, 8'h47,8'h00, 8'h56,8'h02, 8'h82,8'h03,8'h33, 8'h47,8'h03, 8'h01},
        // 4: R6 unequal compare, R7 JEQ not taken, JNE taken, JMP, R3 step
        {8'h82,8'h00,8'h03, 8'h82,8'h01,8'h09, 8'h82,8'h02,8'h14, 8'hA7,8'h00,8'h01,
         8'h55,8'h02, 8'h47,8'h00, 8'h56,8'h02, 8'h47,8'h01, 8'h82,8'h03,8'h1B,
         8'h54,8'h03, 8'h47,8'h01, 8'h47,8'h01, 8'h01},
        // 5: R9 CALL pushes PC+2, RET pops it
        {8'h82,8'h01,8'h0D, 8'h82,8'h00,8'h07, 8'h50,8'h01, 8'h47,8'h00, 8'h47,8'h07,
         8'h01, 8'h47,8'h07, 8'h82,8'h00,8'h08, 8'h11},
        // 6: R11 unknown opcode 0xFF after a print
        {8'h82,8'h00,8'h01, 8'h47,8'h00, 8'hFF},
        // 7: R11 unknown opcode 0x00
        {8'h00},
        // 8: R1 registers reset again after earlier programs
        {8'h47,8'h07, 8'h47,8'h03, 8'h01}
    };
    localparam int LEN [NPROG]  = '{6, 23, 14, 24, 30, 19, 6, 1, 5};
    localparam logic [31:0] EXPV [NPROG] = '{
        32'h2A, 32'h2C10, 32'hF3AAF4, 32'h33, 32'h0309, 32'hF308F4,
        32'h01, 32'h0, 32'hF400};
    localparam int NEXP [NPROG] = '{1, 2, 3, 1, 2, 3, 1, 0, 2};
    localparam bit EXPF [NPROG] = '{0, 0, 0, 0, 0, 0, 1, 1, 0};

    function automatic string req_of(input int i);
        case (i)
            0: return "R4";
            1: return "R5";
            2: return "R8";
            3: return "R7";
            4: return "R3";
            5: return "R9";
            6: return "R11";
            7: return "R11";
            default: return "R1";
        endcase
    endfunction

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    // Load a program in reset, release, optionally poke the load port while running
    task automatic run_prog(input logic [255:0] p, input int len, input bit poke);
        rst = 1'b1;
        step();
        for (int a = 0; a < 32; a++) begin
            load_en   = 1'b1;
            load_addr = 8'(a);
            load_data = (a < len) ? p[(len-1-a)*8 +: 8] : 8'h00;
            step();
        end
        load_en = 1'b0;
        check(!print_valid && !halted && !fault, "R1", "outputs in reset",
              {print_valid, halted, fault}, 0);
        rst = 1'b0;
        if (poke) begin
            load_en   = 1'b1;
            load_addr = 8'd3;
            load_data = 8'h01;
        end
        for (int t = 0; t < 3000 && !halted; t++) step();
        load_en = 1'b0;
        check(halted, "R10", "halted after run", halted, 1);
        repeat (10) step();
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NPROG; i++) begin
            run_prog(PROG[i], LEN[i], 1'b0);
            check(fault == EXPF[i], req_of(i), $sformatf("prog %0d fault", i),
                  fault, EXPF[i]);
            check(halted, "R10", $sformatf("prog %0d halt held", i), halted, 1);
            check(nprint == NEXP[i], req_of(i), $sformatf("prog %0d print count", i),
                  nprint, NEXP[i]);
            for (int k = 0; k < NEXP[i] && k < nprint; k++) begin
                check(cap[k] == EXPV[i][(NEXP[i]-1-k)*8 +: 8], req_of(i),
                      $sformatf("prog %0d print %0d", i, k),
                      cap[k], EXPV[i][(NEXP[i]-1-k)*8 +: 8]);
            end
        end

        // R12: timing of LDI, PRN, HLT after reset release
        run_prog(PROG[0], LEN[0], 1'b0);
        check(first_prn == 7, "R12", "clock of first print", first_prn, 7);
        check(first_halt == 9, "R12", "clock of halted", first_halt, 9);
        check(nprint == 1, "R10", "no print after halt", nprint, 1);
        check(!fault, "R10", "fault stays low on HLT", fault, 0);

        // R2: load port writes while running must not replace PRN with HLT
        run_prog(PROG[0], LEN[0], 1'b1);
        check(nprint == 1, "R2", "print count with load port driven", nprint, 1);
        check(cap[0] == 8'h2A, "R2", "print value with load port driven", cap[0], 8'h2A);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule